// File: doc/BRIEF.md
# Input-Ready Notification Generator

This block sits beside the hardware end of a message input port and converts the port's readiness signal into discrete notifications for the software side. Each fresh readiness indication produces exactly one notification. An indication is fresh when the hardware readiness line is seen high in one of three cases: after a cycle in which it was low, after a cycle in which a message moved through the port, or in the first cycle after reset ends. A readiness level that simply stays high produces nothing further.

Notifications leave on a valid/ready channel whose consumer may stall for any number of cycles. Indications that have not yet been accepted are held in a saturating pending counter. Valid stays high while that counter is nonzero. A sticky flag records any indication that arrived when no room was left. Sends into the port play no part in detection. Only the hardware readiness line and the transfer condition matter.

Top module: `inrdy_notifier`

## Requirements
- R1: While `rst` (active high, sampled on the rising clock edge) is high, `pend_cnt` is 0, `ntf_valid` is low and `overflow` is low after each edge.
- R2: In the first cycle after `rst` is released, if `hw_rdy` is high, one indication is counted, even when `hw_rdy` was already high throughout reset.
- R3: A cycle with `hw_rdy` high that follows a cycle with `hw_rdy` low counts one indication.
- R4: While `hw_rdy` stays high and no transfer occurs, no further indication is counted.
- R5: A transfer is a cycle with both `hw_rdy` and `xfer_rdy` high. The next cycle with `hw_rdy` high counts a new indication, even though `hw_rdy` never dropped.
- R6: `xfer_rdy` high while `hw_rdy` is low counts no indication and leaves `pend_cnt` unchanged.
- R7: An indication raises `pend_cnt` by one at the edge that ends its cycle. Each cycle with `ntf_valid` and `ntf_ready` both high lowers it by one. With `ntf_ready` low, the count and `ntf_valid` hold for any number of cycles.
- R8: When an indication and a handshake fall in the same cycle, `pend_cnt` is unchanged.
- R9: `pend_cnt` never exceeds `MAX_PEND`. An indication that arrives while the count equals `MAX_PEND` and no handshake occurs sets `overflow`. `overflow` then stays set until reset.
- R10: `ntf_valid` is high exactly when `pend_cnt` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_rdy | input | 1 | Hardware side reports it can take a message |
| xfer_rdy | input | 1 | Infrastructure side presents a message |
| ntf_valid | output | 1 | A notification is pending |
| ntf_ready | input | 1 | Consumer accepts the pending notification |
| pend_cnt | output | CW | Number of pending notifications, CW = clog2(MAX_PEND+1) |
| overflow | output | 1 | Sticky: an indication was dropped at saturation |

## Verification
The hardest situation to reach from the ports is a full pending counter in the same cycle as both a fresh indication and a handshake. That cycle must neither overflow nor change the count. The stimulus reaches it by holding `ntf_ready` low and keeping `hw_rdy` and `xfer_rdy` high together, so every cycle re-arms detection and counts a new indication. This fills the counter in a few cycles, forces one overflow, and then opens `ntf_ready` while indications keep arriving. Re-arming with a level that never drops is checked separately, by a single transfer cycle inside a long high stretch of `hw_rdy`.

// File: rtl/inrdy_pkg.sv
package inrdy_pkg;

   typedef enum logic {
      DET_SPENT  = 1'b0,
      DET_PRIMED = 1'b1
   } det_state_e;

   function automatic int cnt_w(input int maxp);
      return (maxp < 1) ? 1 : $clog2(maxp + 1);
   endfunction

endpackage

// File: rtl/inrdy_detect.sv
module inrdy_detect
   import inrdy_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic hw_rdy,
   input  logic xfer_rdy,
   output logic fresh
);

   det_state_e state_q;
   det_state_e state_d;

   // a fresh indication consumes the primed state
   assign fresh = (state_q == DET_PRIMED) && hw_rdy;

   // readiness low or a message moving re-primes for the next cycle
   always_comb begin
      if (!hw_rdy || xfer_rdy) state_d = DET_PRIMED;
      else                     state_d = DET_SPENT;
   end

   // reset leaves detection primed, so readiness right after release counts
   always_ff @(posedge clk) begin
      if (rst) state_q <= DET_PRIMED;
      else     state_q <= state_d;
   end

endmodule

// File: rtl/inrdy_pending.sv
module inrdy_pending
   import inrdy_pkg::*;
#(
   parameter int MAX_PEND = 4,
   localparam int CW = cnt_w(MAX_PEND)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          pop,
   output logic [CW-1:0] cnt,
   output logic          nonzero,
   output logic          lost
);

   logic full;
   logic take;
   logic dec;

   assign nonzero = (cnt != '0);
   assign dec     = pop && nonzero;
   assign take    = inc && (!full || dec);
   assign lost    = inc && full && !dec;

   generate
      if (MAX_PEND == 1) begin : g_flag
         logic flag_q;
         assign full = flag_q;
         assign cnt  = flag_q;
         always_ff @(posedge clk) begin
            if (rst)       flag_q <= 1'b0;
            else if (take) flag_q <= 1'b1;
            else if (dec)  flag_q <= 1'b0;
         end
      end else begin : g_count
         localparam logic [CW-1:0] TOP = CW'(MAX_PEND);
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] cnt_d;
         assign full = (cnt_q == TOP);
         assign cnt  = cnt_q;
         always_comb begin
            unique case ({take, dec})
               2'b10:   cnt_d = cnt_q + CW'(1);
               2'b01:   cnt_d = cnt_q - CW'(1);
               default: cnt_d = cnt_q;
            endcase
         end
         always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_d;
         end
      end
   endgenerate

endmodule

// File: rtl/inrdy_sticky.sv
module inrdy_sticky (
   input  logic clk,
   input  logic rst,
   input  logic set,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (rst)      flag <= 1'b0;
      else if (set) flag <= 1'b1;
   end

endmodule

// File: rtl/inrdy_notifier.sv
module inrdy_notifier
   import inrdy_pkg::*;
#(
   parameter int MAX_PEND = 4,
   localparam int CW = cnt_w(MAX_PEND)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hw_rdy,
   input  logic          xfer_rdy,
   output logic          ntf_valid,
   input  logic          ntf_ready,
   output logic [CW-1:0] pend_cnt,
   output logic          overflow
);

   generate
      if (MAX_PEND < 1) begin : g_bad_depth
         $error("inrdy_notifier: MAX_PEND must be at least 1");
      end
   endgenerate

   logic fresh;
   logic lost;

   inrdy_detect u_detect (
      .clk      (clk),
      .rst      (rst),
      .hw_rdy   (hw_rdy),
      .xfer_rdy (xfer_rdy),
      .fresh    (fresh)
   );

   inrdy_pending #(.MAX_PEND(MAX_PEND)) u_pending (
      .clk     (clk),
      .rst     (rst),
      .inc     (fresh),
      .pop     (ntf_ready),
      .cnt     (pend_cnt),
      .nonzero (ntf_valid),
      .lost    (lost)
   );

   inrdy_sticky u_ovf (
      .clk  (clk),
      .rst  (rst),
      .set  (lost),
      .flag (overflow)
   );

endmodule

// File: rtl/inrdy_notifier_chk.sv
module inrdy_notifier_chk #(
   parameter int MAX_PEND = 4,
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          hw_rdy,
   input logic          xfer_rdy,
   input logic          ntf_valid,
   input logic          ntf_ready,
   input logic [CW-1:0] pend_cnt,
   input logic          overflow
);

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pend_cnt == '0 && !ntf_valid && !overflow)); // R1

   AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (rst)
      (hw_rdy && !xfer_rdy && $past(hw_rdy) && !$past(xfer_rdy) && !$past(rst))
      |=> (pend_cnt <= $past(pend_cnt))); // R4

   AST_LOW_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
      !hw_rdy |=> (pend_cnt <= $past(pend_cnt))); // R6

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      (ntf_valid && !ntf_ready) |=> ntf_valid); // R7

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      pend_cnt <= CW'(MAX_PEND)); // R9

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow); // R9

   AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (rst)
      $rose(overflow) |-> ($past(pend_cnt) == CW'(MAX_PEND))); // R9

   AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
      ntf_valid == (pend_cnt != '0)); // R10

endmodule

bind inrdy_notifier inrdy_notifier_chk #(.MAX_PEND(MAX_PEND), .CW(CW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .hw_rdy    (hw_rdy),
   .xfer_rdy  (xfer_rdy),
   .ntf_valid (ntf_valid),
   .ntf_ready (ntf_ready),
   .pend_cnt  (pend_cnt),
   .overflow  (overflow)
);

// File: tb/sim_inrdy_notifier.sv
`timescale 1ns/1ps
module sim_inrdy_notifier;

   localparam int MAXP = 3;
   localparam int CW   = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          hw_rdy = 1'b0;
   logic          xfer_rdy = 1'b0;
   logic          ntf_ready = 1'b0;
   logic          ntf_valid;
   logic [CW-1:0] pend_cnt;
   logic          overflow;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   inrdy_notifier #(.MAX_PEND(MAXP)) u0 (
      .clk       (clk),
      .rst       (rst),
      .hw_rdy    (hw_rdy),
      .xfer_rdy  (xfer_rdy),
      .ntf_valid (ntf_valid),
      .ntf_ready (ntf_ready),
      .pend_cnt  (pend_cnt),
      .overflow  (overflow)
   );

   task automatic check(input string req, input int exp_cnt, input bit exp_ovf);
      bit exp_v;
      exp_v = (exp_cnt != 0);
      checks++;
      if (int'(pend_cnt) != exp_cnt || ntf_valid != exp_v || overflow != exp_ovf) begin
         errors++;
         $display("FAIL %s: cnt=%0d valid=%0b ovf=%0b expected cnt=%0d valid=%0b ovf=%0b",
                  req, pend_cnt, ntf_valid, overflow, exp_cnt, exp_v, exp_ovf);
      end
   endtask

   // drive one cycle, then check the state after the closing edge
   task automatic cyc(input bit r, input bit h, input bit x, input bit rd,
                      input int exp_cnt, input bit exp_ovf, input string req);
      @(negedge clk);
      rst = r; hw_rdy = h; xfer_rdy = x; ntf_ready = rd;
      @(posedge clk);
      #1;
      check(req, exp_cnt, exp_ovf);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 0, "R1 reset state");
   endtask

   task automatic t_after_reset_and_level();
      cyc(0, 1, 0, 0, 1, 0, "R2 readiness right after reset");
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 1, 0, "R4 level held high");
      cyc(0, 0, 0, 0, 1, 0, "R4 readiness low");
      cyc(0, 1, 0, 0, 2, 0, "R3 rise after low");
   endtask

   task automatic t_drain();
      cyc(0, 1, 0, 1, 1, 0, "R7 handshake decrements");
      cyc(0, 1, 0, 1, 0, 0, "R10 valid drops at zero");
      cyc(0, 1, 0, 0, 0, 0, "R4 still no new indication");
   endtask

   task automatic t_transfer_rearm();
      cyc(0, 1, 1, 0, 0, 0, "R5 transfer cycle while spent");
      cyc(0, 1, 0, 0, 1, 0, "R5 rearm after transfer");
      cyc(0, 1, 0, 0, 1, 0, "R4 no repeat after rearm");
   endtask

   task automatic t_xfer_while_low();
      cyc(0, 0, 1, 0, 1, 0, "R6 transfer request with readiness low");
      cyc(0, 0, 0, 0, 1, 0, "R6 idle low");
   endtask

   task automatic t_same_cycle();
      cyc(0, 1, 0, 1, 1, 0, "R8 indication with handshake");
   endtask

   task automatic t_stall();
      for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 1, 0, "R7 stalled channel holds");
   endtask

   task automatic t_saturate();
      cyc(0, 0, 0, 0, 1, 0, "R3 prepare low");
      cyc(0, 1, 1, 0, 2, 0, "R5 back-to-back transfer fill");
      cyc(0, 1, 1, 0, 3, 0, "R9 reach maximum");
      cyc(0, 1, 1, 0, 3, 1, "R9 overflow at maximum");
      cyc(0, 1, 1, 1, 3, 1, "R8 full with indication and handshake");
      cyc(0, 0, 0, 1, 2, 1, "R9 overflow sticky while draining");
      cyc(0, 0, 0, 0, 2, 1, "R9 overflow still set");
      cyc(1, 0, 0, 0, 0, 0, "R1 reset clears overflow and count");
      cyc(0, 0, 0, 0, 0, 0, "R2 no indication with readiness low after reset");
   endtask

   initial begin
      t_reset();
      t_after_reset_and_level();
      t_drain();
      t_transfer_rearm();
      t_xfer_while_low();
      t_same_cycle();
      t_stall();
      t_saturate();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule